// File: doc/BRIEF.md
# Serial Bus Interrupt Flag Controller

This block holds the single interrupt request flag of a two-wire serial interface. The interface can act as bus master, as bus slave, or run in a clocked synchronous serial format. The serial engine sends the block one-cycle event strobes: start seen, stop seen, repeated start seen, slave address hit, general call hit, byte transfer done, arbitration lost, acknowledge bit received as 1, and wait inserted before the acknowledge. The block also takes the operating mode and the control bits that qualify those events. From these it decides when the flag is raised.

The flag is cleared in three ways. Software can clear it with a read-then-write handshake. A data register access by the transfer controller also clears it, and so does clearing the transmit-empty status. The interrupt line is the flag gated by an enable bit. The CPU reads the flag through `flag_o`.

Top module: `sbus_irq_flag`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `flag_o` and `irq_o` are 0.
- R2: Mode encoding is `mode_i` 00 master, 01 slave, 10 synchronous serial, 11 idle. In master mode the flag is set one cycle after a transfer-done strobe or an arbitration-lost strobe. It is also set after a start strobe seen while `start_req_i` is 1. A start strobe with `start_req_i` at 0 does not set it.
- R3: In master mode a wait strobe sets the flag only when `wait_en_i` is 1.
- R4: In master or slave mode, a received-acknowledge-is-1 strobe sets the flag only when `ack_chk_en_i` is 1 and `wait_en_i` is 0.
- R5: In slave mode the flag is set by a hit on any slave address bit of `ev_addr_match_i`. It is also set by a general call strobe, a repeated start strobe and a transfer-done strobe.
- R6: In slave mode a stop strobe sets the flag only when `stop_mask_i` is 0.
- R7: In synchronous serial mode only transfer-done and start strobes set the flag; arbitration-lost and address hits are ignored. In idle mode no strobe sets it.
- R8: A write of 0 (`reg_wr_i`=1 with `reg_wbit_i`=0) clears the flag only if `reg_rd_i` has been seen in an earlier cycle while the flag was 1. A write of 0 without that read, and any write of 1, leave the flag unchanged.
- R9: A pulse on `dma_acc_i` clears the flag in the next cycle.
- R10: A pulse on `txe_clr_i` clears the flag in the next cycle.
- R11: When a set event and a clear action fall in the same cycle, the flag is 1 afterwards.
- R12: Any clear action discards a pending read qualification. After a new set, a write of 0 needs a fresh read before it clears the flag.
- R13: `irq_o` is 1 exactly when the flag is 1 and `irq_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating mode (00 master, 01 slave, 10 sync serial, 11 idle) |
| start_req_i | input | 1 | CPU has requested a start condition |
| wait_en_i | input | 1 | Wait insertion before acknowledge enabled |
| ack_chk_en_i | input | 1 | Received acknowledge checking enabled |
| stop_mask_i | input | 1 | Masks stop detection as a flag source in slave mode |
| irq_en_i | input | 1 | Interrupt output enable |
| ev_start_i | input | 1 | Start condition detected |
| ev_stop_i | input | 1 | Stop condition detected |
| ev_rstart_i | input | 1 | Repeated start condition detected |
| ev_addr_match_i | input | NUM_SVA | One strobe per own slave address matched |
| ev_gcall_i | input | 1 | General call address detected |
| ev_xfer_done_i | input | 1 | Byte transfer complete (transmit empty or receive full set) |
| ev_arb_lost_i | input | 1 | Arbitration lost on bus conflict |
| ev_nack_i | input | 1 | Acknowledge bit received as 1 |
| ev_wait_i | input | 1 | Wait inserted between data and acknowledge |
| reg_rd_i | input | 1 | CPU read of the flag |
| reg_wr_i | input | 1 | CPU write of the flag |
| reg_wbit_i | input | 1 | Value written to the flag |
| dma_acc_i | input | 1 | Transfer controller data register access |
| txe_clr_i | input | 1 | Transmit-empty status cleared to 0 |
| flag_o | output | 1 | Interrupt request flag (CPU read value) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a set event and a clear action in the same cycle while a read qualification is already held. The stimulus sets the flag, reads it, and in the next cycle drives a qualified write of 0 together with a transfer-done strobe. A second pass drives a transfer-controller access together with a transfer-done strobe. Stale qualification is reached by reading, clearing through the transfer controller, setting again and writing 0 without a new read. A behavioural model in the bench tracks the flag and the qualification and is compared with the outputs every cycle.

// File: rtl/sbif_pkg.sv
package sbif_pkg;

   typedef enum logic [1:0] {
      SBIF_MASTER = 2'b00,
      SBIF_SLAVE  = 2'b01,
      SBIF_SYNC   = 2'b10,
      SBIF_IDLE   = 2'b11
   } sbif_mode_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rstart;
      logic sva_hit;
      logic gcall;
      logic xfer_done;
      logic arb_lost;
      logic nack;
      logic wait_ins;
   } sbif_evt_t;

   typedef struct packed {
      logic start_req;
      logic wait_en;
      logic ack_chk_en;
      logic stop_mask;
   } sbif_ctl_t;

endpackage

// File: rtl/sbif_addr_hit.sv
module sbif_addr_hit #(
   parameter int NUM_SVA = 2
) (
   input  logic [NUM_SVA-1:0] match_i,
   output logic               hit_o
);
   localparam int CHAIN_W = NUM_SVA + 1;

   logic [CHAIN_W-1:0] chain;

   assign chain[0] = 1'b0;

   generate
      for (genvar g = 0; g < NUM_SVA; g++) begin : g_or
         assign chain[g+1] = chain[g] | match_i[g];
      end
   endgenerate

   assign hit_o = chain[CHAIN_W-1];
endmodule

// File: rtl/sbif_set_logic.sv
module sbif_set_logic
   import sbif_pkg::*;
#(
   parameter bit SYNC_EN = 1'b1
) (
   input  sbif_mode_e mode_i,
   input  sbif_ctl_t  ctl_i,
   input  sbif_evt_t  evt_i,
   output logic       set_o
);
   logic nack_ok;
   logic mst_set;
   logic slv_set;
   logic syn_set;

   always_comb begin
      nack_ok = ctl_i.ack_chk_en & ~ctl_i.wait_en & evt_i.nack;
      mst_set = (evt_i.start & ctl_i.start_req)
              | (evt_i.wait_ins & ctl_i.wait_en)
              | evt_i.xfer_done
              | evt_i.arb_lost
              | nack_ok;
      slv_set = evt_i.sva_hit
              | evt_i.gcall
              | evt_i.rstart
              | evt_i.xfer_done
              | nack_ok
              | (evt_i.stop & ~ctl_i.stop_mask);
   end

   generate
      if (SYNC_EN) begin : g_sync
         assign syn_set = evt_i.xfer_done | evt_i.start;
      end else begin : g_nosync
         assign syn_set = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (mode_i)
         SBIF_MASTER: set_o = mst_set;
         SBIF_SLAVE:  set_o = slv_set;
         SBIF_SYNC:   set_o = syn_set;
         default:     set_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/sbif_clr_ctl.sv
module sbif_clr_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   input  logic dma_i,
   input  logic txe_clr_i,
   output logic clr_o,
   output logic qual_o
);
   logic qual_q;
   logic qual_d;
   logic sw_clr;

   always_comb begin
      sw_clr = wr_i & ~wbit_i & qual_q;
      clr_o  = sw_clr | dma_i | txe_clr_i;
      if (clr_o)               qual_d = 1'b0;
      else if (rd_i && flag_i) qual_d = 1'b1;
      else if (!flag_i)        qual_d = 1'b0;
      else                     qual_d = qual_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) qual_q <= 1'b0;
      else        qual_q <= qual_d;
   end

   assign qual_o = qual_q;
endmodule

// File: rtl/sbif_flag_reg.sv
module sbif_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic irq_en_i,
   output logic flag_o,
   output logic irq_o
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/sbus_irq_flag.sv
module sbus_irq_flag
   import sbif_pkg::*;
#(
   parameter int NUM_SVA = 2,
   parameter bit SYNC_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_i,
   input  logic               start_req_i,
   input  logic               wait_en_i,
   input  logic               ack_chk_en_i,
   input  logic               stop_mask_i,
   input  logic               irq_en_i,
   input  logic               ev_start_i,
   input  logic               ev_stop_i,
   input  logic               ev_rstart_i,
   input  logic [NUM_SVA-1:0] ev_addr_match_i,
   input  logic               ev_gcall_i,
   input  logic               ev_xfer_done_i,
   input  logic               ev_arb_lost_i,
   input  logic               ev_nack_i,
   input  logic               ev_wait_i,
   input  logic               reg_rd_i,
   input  logic               reg_wr_i,
   input  logic               reg_wbit_i,
   input  logic               dma_acc_i,
   input  logic               txe_clr_i,
   output logic               flag_o,
   output logic               irq_o
);
   generate
      if (NUM_SVA < 1 || NUM_SVA > 4) begin : g_bad_sva
         $error("sbus_irq_flag: NUM_SVA must be 1..4");
      end
   endgenerate

   sbif_evt_t  evt;
   sbif_ctl_t  ctl;
   sbif_mode_e mode;
   logic       sva_hit;
   logic       set_w;
   logic       clr_w;
   logic       qual_w;

   assign mode = sbif_mode_e'(mode_i);

   sbif_addr_hit #(.NUM_SVA(NUM_SVA)) u_hit (
      .match_i (ev_addr_match_i),
      .hit_o   (sva_hit)
   );

   always_comb begin
      evt.start     = ev_start_i;
      evt.stop      = ev_stop_i;
      evt.rstart    = ev_rstart_i;
      evt.sva_hit   = sva_hit;
      evt.gcall     = ev_gcall_i;
      evt.xfer_done = ev_xfer_done_i;
      evt.arb_lost  = ev_arb_lost_i;
      evt.nack      = ev_nack_i;
      evt.wait_ins  = ev_wait_i;
      ctl.start_req  = start_req_i;
      ctl.wait_en    = wait_en_i;
      ctl.ack_chk_en = ack_chk_en_i;
      ctl.stop_mask  = stop_mask_i;
   end

   sbif_set_logic #(.SYNC_EN(SYNC_EN)) u_set (
      .mode_i (mode),
      .ctl_i  (ctl),
      .evt_i  (evt),
      .set_o  (set_w)
   );

   sbif_clr_ctl u_clr (
      .clk       (clk),
      .rst_n     (rst_n),
      .flag_i    (flag_o),
      .rd_i      (reg_rd_i),
      .wr_i      (reg_wr_i),
      .wbit_i    (reg_wbit_i),
      .dma_i     (dma_acc_i),
      .txe_clr_i (txe_clr_i),
      .clr_o     (clr_w),
      .qual_o    (qual_w)
   );

   sbif_flag_reg u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_w),
      .clr_i    (clr_w),
      .irq_en_i (irq_en_i),
      .flag_o   (flag_o),
      .irq_o    (irq_o)
   );
endmodule

// File: rtl/sbus_irq_flag_chk.sv
module sbus_irq_flag_chk (
   input logic clk,
   input logic rst_n,
   input logic flag_o,
   input logic irq_o,
   input logic irq_en_i,
   input logic set_w,
   input logic qual_w,
   input logic reg_wr_i,
   input logic reg_wbit_i,
   input logic dma_acc_i,
   input logic txe_clr_i
);
   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_w |=> flag_o);

   // R9
   dma_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_acc_i && !set_w) |=> !flag_o);

   // R10
   txe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txe_clr_i && !set_w) |=> !flag_o);

   // R8
   unqual_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && reg_wr_i && !reg_wbit_i && !qual_w && !dma_acc_i && !txe_clr_i) |=> flag_o);

   // R12
   qual_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qual_w |-> flag_o);

   // R13
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i |-> !irq_o);

   // R2
   rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(set_w));
endmodule

bind sbus_irq_flag sbus_irq_flag_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .flag_o     (flag_o),
   .irq_o      (irq_o),
   .irq_en_i   (irq_en_i),
   .set_w      (set_w),
   .qual_w     (qual_w),
   .reg_wr_i   (reg_wr_i),
   .reg_wbit_i (reg_wbit_i),
   .dma_acc_i  (dma_acc_i),
   .txe_clr_i  (txe_clr_i)
);

// File: tb/sbus_irq_flag_tb_top.sv
`timescale 1ns/1ps
module sbus_irq_flag_tb_top;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n, start_req, wait_en, ack_chk_en, stop_mask, irq_en;
   logic [1:0] mode;
   logic       ev_start, ev_stop, ev_rstart, ev_gcall, ev_xfer, ev_arb, ev_nack, ev_wait;
   logic [1:0] ev_addr;
   logic       rd, wr, wbit, dma, txe_clr;
   logic       flag_o, irq_o;

   sbus_irq_flag dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .start_req_i(start_req),
      .wait_en_i(wait_en), .ack_chk_en_i(ack_chk_en), .stop_mask_i(stop_mask),
      .irq_en_i(irq_en), .ev_start_i(ev_start), .ev_stop_i(ev_stop),
      .ev_rstart_i(ev_rstart), .ev_addr_match_i(ev_addr), .ev_gcall_i(ev_gcall),
      .ev_xfer_done_i(ev_xfer), .ev_arb_lost_i(ev_arb), .ev_nack_i(ev_nack),
      .ev_wait_i(ev_wait), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wbit_i(wbit),
      .dma_acc_i(dma), .txe_clr_i(txe_clr), .flag_o(flag_o), .irq_o(irq_o)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    m_flag = 0;
   bit    m_qual = 0;
   string tag = "R1";

   function automatic bit ref_set();
      bit nk;
      nk = ack_chk_en && !wait_en && ev_nack;
      case (mode)
         2'b00: return (ev_start && start_req) || (ev_wait && wait_en) || ev_xfer || ev_arb || nk;
         2'b01: return (ev_addr != 0) || ev_gcall || ev_rstart || ev_xfer || nk || (ev_stop && !stop_mask);
         2'b10: return ev_xfer || ev_start;
         default: return 0;
      endcase
   endfunction

   task automatic chk(string t, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", t, act, exp, $time);
      end
   endtask

   task automatic step();
      bit s, c;
      @(posedge clk);
      if (!rst_n) begin
         m_flag = 0; m_qual = 0;
      end else begin
         s = ref_set();
         c = dma || txe_clr || (wr && !wbit && m_qual);
         if (c) m_qual = 0;
         else if (rd && m_flag) m_qual = 1;
         if (s) m_flag = 1;
         else if (c) m_flag = 0;
      end
      @(negedge clk);
      chk(tag, flag_o, m_flag);
      chk({tag, " (R13 irq)"}, irq_o, m_flag & irq_en);
      ev_start = 0; ev_stop = 0; ev_rstart = 0; ev_gcall = 0; ev_xfer = 0;
      ev_arb = 0; ev_nack = 0; ev_wait = 0; ev_addr = 0;
      rd = 0; wr = 0; wbit = 0; dma = 0; txe_clr = 0;
   endtask

   task automatic expect_flag(logic exp);
      chk({tag, " directed"}, flag_o, exp);
   endtask

   task automatic clr_dma();
      dma = 1; step();
   endtask

   initial begin
      #(100000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      rst_n = 0; mode = 0; start_req = 0; wait_en = 0; ack_chk_en = 0;
      stop_mask = 0; irq_en = 1;
      ev_start = 0; ev_stop = 0; ev_rstart = 0; ev_gcall = 0; ev_xfer = 0;
      ev_arb = 0; ev_nack = 0; ev_wait = 0; ev_addr = 0;
      rd = 0; wr = 0; wbit = 0; dma = 0; txe_clr = 0;
      @(negedge clk);
      tag = "R1"; ev_xfer = 1; step(); expect_flag(0);
      step(); expect_flag(0);
      rst_n = 1; step(); expect_flag(0);

      tag = "R2"; mode = 2'b00;
      ev_start = 1; step(); expect_flag(0);
      start_req = 1; ev_start = 1; step(); expect_flag(1);
      start_req = 0;
      tag = "R10"; txe_clr = 1; step(); expect_flag(0);
      tag = "R2"; ev_xfer = 1; step(); expect_flag(1);
      tag = "R9"; clr_dma(); expect_flag(0);
      tag = "R2"; ev_arb = 1; step(); expect_flag(1); clr_dma();

      tag = "R3"; ev_wait = 1; step(); expect_flag(0);
      wait_en = 1; ev_wait = 1; step(); expect_flag(1); clr_dma();

      tag = "R4"; ack_chk_en = 1; ev_nack = 1; step(); expect_flag(0);
      wait_en = 0; ev_nack = 1; step(); expect_flag(1); clr_dma();
      ack_chk_en = 0; ev_nack = 1; step(); expect_flag(0);
      mode = 2'b01; ack_chk_en = 1; ev_nack = 1; step(); expect_flag(1); clr_dma();
      ack_chk_en = 0;

      tag = "R5";
      ev_addr = 2'b01; step(); expect_flag(1); clr_dma();
      ev_addr = 2'b10; step(); expect_flag(1); clr_dma();
      ev_gcall = 1; step(); expect_flag(1); clr_dma();
      ev_rstart = 1; step(); expect_flag(1); clr_dma();
      ev_xfer = 1; step(); expect_flag(1); clr_dma();
      ev_arb = 1; step(); expect_flag(0);

      tag = "R6"; stop_mask = 1; ev_stop = 1; step(); expect_flag(0);
      stop_mask = 0; ev_stop = 1; step(); expect_flag(1); clr_dma();

      tag = "R7"; mode = 2'b10;
      ev_arb = 1; step(); expect_flag(0);
      ev_addr = 2'b11; ev_gcall = 1; step(); expect_flag(0);
      ev_xfer = 1; step(); expect_flag(1); clr_dma();
      ev_start = 1; step(); expect_flag(1); clr_dma();
      mode = 2'b11; ev_xfer = 1; ev_start = 1; ev_arb = 1; step(); expect_flag(0);
      mode = 2'b10;

      tag = "R8";
      ev_xfer = 1; step();
      wr = 1; wbit = 0; step(); expect_flag(1);
      rd = 1; step();
      wr = 1; wbit = 1; step(); expect_flag(1);
      wr = 1; wbit = 0; step(); expect_flag(0);
      rd = 1; step();
      ev_xfer = 1; step();
      wr = 1; wbit = 0; step(); expect_flag(1);
      rd = 1; wr = 1; wbit = 0; step(); expect_flag(1);
      wr = 1; wbit = 0; step(); expect_flag(0);

      tag = "R11";
      ev_xfer = 1; step(); rd = 1; step();
      wr = 1; wbit = 0; ev_xfer = 1; step(); expect_flag(1);
      dma = 1; ev_xfer = 1; step(); expect_flag(1);
      txe_clr = 1; ev_start = 1; step(); expect_flag(1);
      clr_dma();

      tag = "R12";
      ev_xfer = 1; step(); rd = 1; step();
      dma = 1; step(); expect_flag(0);
      ev_xfer = 1; step();
      wr = 1; wbit = 0; step(); expect_flag(1);
      rd = 1; step(); wr = 1; wbit = 0; step(); expect_flag(0);

      tag = "R13";
      ev_xfer = 1; irq_en = 0; step(); chk("R13", irq_o, 0);
      irq_en = 1; step(); chk("R13", irq_o, 1);
      clr_dma(); chk("R13", irq_o, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule